// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting timer/counter units that share one small register interface. Each unit advances either once per machine cycle, which is a fixed number of system clocks set by a prescaler parameter, or once per falling edge seen on its external count input. The count input is sampled once per machine cycle. Counting is allowed by a run bit and can also be tied to an external gate input, so a unit can measure how long a pulse stays high.

Each unit has four operating modes: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself from its high byte, and a split mode. In split mode unit 0 becomes two independent 8-bit counters. Its upper half takes unit 1's run bit and unit 1's overflow flag, and unit 1 keeps running but no longer raises its flag. Overflow flags are cleared by acknowledge inputs from an interrupt controller. Unit 1 also drives a one-cycle overflow strobe that a serial port can use as a baud tick.

Top module: `dual_timer_counter`

## Requirements
- R1: In timer function, a running unit advances exactly once per TICK_DIV clock cycles. Over any window of k*TICK_DIV consecutive enabled cycles it advances exactly k.
- R2: When a counter wraps from all ones to zero, the unit's overflow flag is set. Flag 0 appears on ovf_flag[0] and on control bit 2. Flag 1 appears on ovf_flag[1] and on control bit 3.
- R3: Pulsing ovf_ack[i] for one cycle clears flag i. If an overflow happens in the same cycle, the set wins.
- R4: While the run bit is 0, the count holds its value.
- R5: When the gate bit (bit 3 of a unit's mode field) is 1, the unit counts only while ext_gate[i] is high.
- R6: When the count-source bit (bit 2 of the mode field) is 1, the unit counts falling edges of ext_count[i]. An edge counts when one machine-cycle sample is high and the next is low. Pulses arriving while the run bit is 0 are not counted.
- R7: Mode 2 (reload): the low byte counts. When it overflows from 0xFF, it reloads from the high byte and the flag is set. The high byte does not change.
- R8: Mode 0 (13-bit): the counter is formed from high byte and low-byte bits 4:0. Bits 7:5 of the low byte are left unchanged. The flag is set when the counter wraps from 0x1FFF.
- R9: Mode 1 (16-bit): high and low bytes form one 16-bit counter.
- R10: Mode 3 on unit 0 (split):
  - The low byte counts under unit 0's run, gate and source bits and sets flag 0.
  - The high byte counts machine cycles while run bit 1 is set, and its overflow sets flag 1.
  - Unit 1's own overflows no longer set flag 1.
- R11: Mode 3 on unit 1 stops unit 1 and holds its count.
- R12: baud_pulse is high for one cycle after each unit 1 overflow, whether or not unit 0 is in split mode.
- R13: Register map:

  | Address | Register |
  |---|---|
  | 0 | mode register (unit 0 in bits 3:0, unit 1 in bits 7:4; each field is {gate, source, mode[1:0]}) |
  | 1 | control register (bit 0 = run 0, bit 1 = run 1, bits 2 and 3 = read-only flags) |
  | 2 | unit 0 low byte |
  | 3 | unit 0 high byte |
  | 4 | unit 1 low byte |
  | 5 | unit 1 high byte |

  All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| ext_count | input | 2 | External count inputs, one per unit |
| ext_gate | input | 2 | External gate inputs, one per unit |
| ovf_ack | input | 2 | Flag acknowledge, one per unit |
| ovf_flag | output | 2 | Overflow flags |
| baud_pulse | output | 1 | One-cycle strobe on each unit 1 overflow |

## Verification
The bench builds the block with TICK_DIV set to 3. A machine cycle is then only three clocks, so the tests can reach wrap-arounds, reloads and split-mode overflows within a few ticks. Expected counts use the rule that a window of k*3 enabled cycles adds exactly k, whatever the prescaler phase. This lets every mode be checked arithmetically from loaded start values placed just below overflow. External count inputs are toggled at both half and full sampling rate to show that every falling edge is counted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext_sel;
    tmode_e mode;
  } tcfg_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_U0LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_U0HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_U1LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_U1HI = 3'd5;

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate

endmodule

// File: rtl/edge_sampler.sv
module edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic samp_q, samp_d;

  always_comb begin
    samp_d = tick ? pin : samp_q;
    fall   = tick & samp_q & ~pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_d;
  end

endmodule

// File: rtl/count_unit.sv
module count_unit
  import tmr_pkg::*;
#(
  parameter bit SPLIT_CAPABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              step,
  input  logic              split_step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf,
  output logic              hi_ovf
);
  localparam int PRE_W = 5;

  logic [BYTE_W-1:0] lo_d, hi_d;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ovf    = 1'b0;
    hi_ovf = 1'b0;
    case (mode)
      MODE_13: begin
        if (step) begin
          if (&lo_q[PRE_W-1:0]) begin
            lo_d[PRE_W-1:0] = '0;
            hi_d            = hi_q + 1'b1;
            ovf             = &hi_q;
          end else begin
            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
      end
      MODE_16: begin
        if (step) begin
          {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
          ovf          = (&hi_q) & (&lo_q);
        end
      end
      MODE_RELOAD: begin
        if (step) begin
          if (&lo_q) begin
            lo_d = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
      end
      default: begin
        if (SPLIT_CAPABLE) begin
          if (step) begin
            lo_d = lo_q + 1'b1;
            ovf  = &lo_q;
          end
          if (split_step) begin
            hi_d   = hi_q + 1'b1;
            hi_ovf = &hi_q;
          end
        end
      end
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !split_step && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q))); // R4

  AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && step && (&lo_q) && !wr_lo && !wr_hi) |=> (lo_q == $past(hi_q) && $stable(hi_q))); // R7

endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import tmr_pkg::*;
#(
  parameter int TICK_DIV = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_waddr,
  input  logic [7:0]  reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [7:0]  reg_rdata,
  input  logic [1:0]  ext_count,
  input  logic [1:0]  ext_gate,
  input  logic [1:0]  ovf_ack,
  output logic [1:0]  ovf_flag,
  output logic        baud_pulse
);
  localparam int NUNIT = 2;

  logic [BYTE_W-1:0] mode_q, mode_d;
  logic [NUNIT-1:0]  run_q, run_d;
  logic [NUNIT-1:0]  flag_q, flag_d;
  logic              baud_q, baud_d;

  logic              tick;
  logic              t0_split;
  logic              split_step;
  tcfg_t             cfg   [NUNIT];
  logic [NUNIT-1:0]  fall, step, ovf, hi_ovf, wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo_q [NUNIT];
  logic [BYTE_W-1:0] hi_q [NUNIT];

  tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  always_comb begin
    cfg[0]     = tcfg_t'(mode_q[3:0]);
    cfg[1]     = tcfg_t'(mode_q[7:4]);
    t0_split   = (cfg[0].mode == MODE_SPLIT);
    split_step = tick & run_q[1] & t0_split;
  end

  generate
    for (genvar i = 0; i < NUNIT; i++) begin : g_unit
      logic enable;

      edge_sampler u_edge (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(ext_count[i]), .fall(fall[i])
      );

      always_comb begin
        enable  = run_q[i] & (~cfg[i].gate | ext_gate[i]);
        step[i] = enable & (cfg[i].ext_sel ? fall[i] : tick);
        wr_lo[i] = reg_wr && (reg_waddr == A_U0LO + 3'(2 * i));
        wr_hi[i] = reg_wr && (reg_waddr == A_U0HI + 3'(2 * i));
      end

      count_unit #(.SPLIT_CAPABLE(i == 0)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cfg[i].mode),
        .step       (step[i]),
        .split_step ((i == 0) ? split_step : 1'b0),
        .wr_lo      (wr_lo[i]),
        .wr_hi      (wr_hi[i]),
        .wdata      (reg_wdata),
        .lo_q       (lo_q[i]),
        .hi_q       (hi_q[i]),
        .ovf        (ovf[i]),
        .hi_ovf     (hi_ovf[i])
      );
    end
  endgenerate

  // next state
  always_comb begin
    mode_d = (reg_wr && reg_waddr == A_MODE) ? reg_wdata : mode_q;
    run_d  = (reg_wr && reg_waddr == A_CTL) ? reg_wdata[1:0] : run_q;
    flag_d[0] = ovf[0] | (flag_q[0] & ~ovf_ack[0]);
    flag_d[1] = (t0_split ? (|hi_ovf) : ovf[1]) | (flag_q[1] & ~ovf_ack[1]);
    baud_d = ovf[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      baud_q <= baud_d;
    end
  end

  always_comb begin
    case (reg_raddr)
      A_MODE:  reg_rdata = mode_q;
      A_CTL:   reg_rdata = {4'b0, flag_q, run_q};
      A_U0LO:  reg_rdata = lo_q[0];
      A_U0HI:  reg_rdata = hi_q[0];
      A_U1LO:  reg_rdata = lo_q[1];
      A_U1HI:  reg_rdata = hi_q[1];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag   = flag_q;
  assign baud_pulse = baud_q;

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] |=> ovf_flag[0]); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack[0] && !ovf[0]) |=> !ovf_flag[0]); // R3

  AST_SPLIT_T1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && ovf[1] && !hi_ovf[0] && !flag_q[1]) |=> !ovf_flag[1]); // R10

  AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1].mode == MODE_SPLIT && !wr_lo[1] && !wr_hi[1]) |=> ($stable(lo_q[1]) && $stable(hi_q[1]))); // R11

endmodule

// File: tb/dual_timer_counter_tb_top.sv
`timescale 1ns/1ps
module dual_timer_counter_tb_top;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_waddr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ext_count = '0;
  logic [1:0] ext_gate = '0;
  logic [1:0] ovf_ack = '0;
  logic [1:0] ovf_flag;
  logic       baud_pulse;

  int checks = 0;
  int errors = 0;
  int baud_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_timer_counter #(.TICK_DIV(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ext_count(ext_count), .ext_gate(ext_gate), .ovf_ack(ovf_ack),
    .ovf_flag(ovf_flag), .baud_pulse(baud_pulse)
  );

  always @(negedge clk) if (rst_n && baud_pulse) baud_cnt++;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_raddr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd16(input int unit, output int v);
    int lo, hi;
    rd(3'(2 + 2 * unit), lo);
    rd(3'(3 + 2 * unit), hi);
    v = (hi << 8) | lo;
    @(negedge clk);
  endtask

  task automatic load(input int unit, input int val);
    wr(3'(2 + 2 * unit), val[7:0]);
    wr(3'(3 + 2 * unit), val[15:8]);
  endtask

  task automatic run_window(input logic [1:0] runs, input int k);
    wr(3'd1, {6'b0, runs});
    repeat (k * P - 1) @(negedge clk);
    wr(3'd1, 8'h00);
  endtask

  task automatic ack(input int unit);
    ovf_ack[unit] = 1'b1;
    @(negedge clk);
    ovf_ack[unit] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R13 reset register", v, 0);
    end
    chk("R2 reset flags", int'(ovf_flag), 0);
    chk("R12 reset baud", int'(baud_pulse), 0);

    // R9 / R1 / R2 16-bit wrap
    wr(3'd0, 8'h01);
    load(0, 16'hFFFD);
    run_window(2'b01, 5);
    rd16(0, v);
    chk("R9 16-bit wrap value", v, 16'h0002);
    chk("R2 flag0 set", int'(ovf_flag[0]), 1);
    rd(3'd1, v);
    chk("R2 ctl flag0 bit", v, 8'h04);

    // R4 hold when stopped
    repeat (10) @(negedge clk);
    rd16(0, v);
    chk("R4 hold while stopped", v, 16'h0002);

    // R3 ack
    ack(0);
    chk("R3 ack clears flag0", int'(ovf_flag[0]), 0);

    // R1 exact rate
    load(0, 16'h0010);
    run_window(2'b01, 7);
    rd16(0, v);
    chk("R1 seven ticks", v, 16'h0017);

    // R8 13-bit mode
    wr(3'd0, 8'h00);
    load(0, 16'h121E);
    run_window(2'b01, 3);
    rd16(0, v);
    chk("R8 13-bit carry", v, 16'h1301);
    chk("R8 no flag", int'(ovf_flag[0]), 0);
    load(0, 16'hFFFF);
    run_window(2'b01, 1);
    rd16(0, v);
    chk("R8 13-bit wrap keeps lo[7:5]", v, 16'h00E0);
    chk("R8 flag on wrap", int'(ovf_flag[0]), 1);
    ack(0);

    // R7 reload
    wr(3'd0, 8'h02);
    load(0, 16'hF0FE);
    run_window(2'b01, 4);
    rd16(0, v);
    chk("R7 reload value", v, 16'hF0F2);
    chk("R7 reload flag", int'(ovf_flag[0]), 1);
    ack(0);

    // R5 gate
    wr(3'd0, 8'h09);
    load(0, 16'h0000);
    ext_gate[0] = 1'b0;
    run_window(2'b01, 6);
    rd16(0, v);
    chk("R5 gate low blocks", v, 0);
    ext_gate[0] = 1'b1;
    run_window(2'b01, 6);
    rd16(0, v);
    chk("R5 gate high counts", v, 6);
    ext_gate[0] = 1'b0;

    // R6 counter function
    wr(3'd0, 8'h05);
    load(0, 16'h0000);
    wr(3'd1, 8'h01);
    for (int i = 0; i < 4; i++) begin
      ext_count[0] = 1'b1; repeat (2 * P) @(negedge clk);
      ext_count[0] = 1'b0; repeat (2 * P) @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      ext_count[0] = 1'b1; repeat (P) @(negedge clk);
      ext_count[0] = 1'b0; repeat (P) @(negedge clk);
    end
    repeat (P) @(negedge clk);
    wr(3'd1, 8'h00);
    rd16(0, v);
    chk("R6 falling edges counted", v, 9);
    for (int i = 0; i < 3; i++) begin
      ext_count[0] = 1'b1; repeat (2 * P) @(negedge clk);
      ext_count[0] = 1'b0; repeat (2 * P) @(negedge clk);
    end
    rd16(0, v);
    chk("R6 no count while stopped", v, 9);

    // R10 split mode
    wr(3'd0, 8'h13);
    load(0, 16'hFE40);
    load(1, 16'h0000);
    run_window(2'b10, 3);
    rd16(0, v);
    chk("R10 split high half counts on run1", v, 16'h0140);
    chk("R10 split sets flag1", int'(ovf_flag[1]), 1);
    chk("R10 split flag0 clear", int'(ovf_flag[0]), 0);
    rd16(1, v);
    chk("R10 unit1 still runs", v, 3);
    ack(1);
    run_window(2'b01, 2);
    rd16(0, v);
    chk("R10 low half on run0 only", v, 16'h0142);

    // R12 baud strobe while split
    load(1, 16'hFFFE);
    load(0, 16'h0000);
    base = baud_cnt;
    run_window(2'b10, 3);
    rd16(1, v);
    chk("R12 unit1 wrapped in split", v, 1);
    chk("R12 one baud pulse in split", baud_cnt - base, 1);
    chk("R10 unit1 wrap leaves flag1", int'(ovf_flag[1]), 0);

    // R12 baud strobe in reload mode
    wr(3'd0, 8'h20);
    load(1, 16'hFDFD);
    base = baud_cnt;
    run_window(2'b10, 6);
    rd16(1, v);
    chk("R7 unit1 reload value", v, 16'hFDFD);
    chk("R12 two baud pulses", baud_cnt - base, 2);
    chk("R2 flag1 set", int'(ovf_flag[1]), 1);
    ack(1);

    // R11 unit1 mode 3 holds
    wr(3'd0, 8'h31);
    load(1, 16'h1234);
    base = baud_cnt;
    run_window(2'b10, 5);
    rd16(1, v);
    chk("R11 unit1 held", v, 16'h1234);
    chk("R11 no flag1", int'(ovf_flag[1]), 0);
    chk("R11 no baud", baud_cnt - base, 0);

    // R13 register readback
    rd(3'd0, v);
    chk("R13 mode readback", v, 8'h31);
    wr(3'd1, 8'hFF);
    rd(3'd1, v);
    chk("R13 ctl run bits only", v, 8'h03);
    wr(3'd1, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule